// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block is the alarm half of a BCD real-time clock. Software programs the alarm time as BCD values: second, minute, hour, day of month, month and a three-digit year. It also programs a control register. That register has one enable bit for each field and one global alarm enable.

The calendar counter sits outside the block. It supplies the current time as BCD buses, together with a one-cycle strobe in the cycle just after it advances. On each strobe, the block compares every enabled field with the current time. A match on any single enabled field is enough to raise the alarm; the fields are ORed, not ANDed.

A match sets a sticky pending bit, and that bit drives the alarm interrupt. The pending bit is cleared by writing one to status bit 1.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset the control register, every alarm field register and the pending status read as zero, and `alarm_irq` is low.
- R2: Writes keep only the field width. Second and minute keep 7 bits, hour and day of month keep 6 bits, month keeps 5 bits, year keeps 12 bits and control keeps 7 bits. Read-back returns the stored value with all higher bits zero.
- R3: Control bit 0 enables the second compare, bit 1 the minute, bit 2 the hour, bit 3 the day of month, bit 4 the month and bit 5 the year. A disabled field never causes an alarm.
- R4: Control bit 6 is the global enable. While it is clear, no strobe sets the pending bit, even if every field matches.
- R5: The alarm fires when at least one enabled field equals its current-time input.
- R6: Comparison happens only in a cycle with `sec_strobe` high. The pending bit and `alarm_irq` rise at the clock edge that samples that strobe, and at no other time.
- R7: The year compare covers 12 bits: units and tens in bits [7:0], hundreds in bits [11:8]. A difference in the hundreds digit alone prevents a year match.
- R8: Pending is sticky. `alarm_irq` equals the pending bit, and the pending bit reads as bit 1 of the status register (select 7).
- R9: Writing status with bit 1 set clears pending and lowers `alarm_irq`. A status write with bit 1 clear has no effect. If a clear and a new match fall on the same edge, pending stays set.

Register selects for `wr_sel` and `rd_sel`: 0 control, 1 second, 2 minute, 3 hour, 4 day of month, 5 month, 6 year, 7 status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | DW | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | DW | Combinational read data |
| now_sec | input | 8 | Current second, BCD |
| now_min | input | 8 | Current minute, BCD |
| now_hour | input | 8 | Current hour, BCD |
| now_mday | input | 8 | Current day of month, BCD |
| now_mon | input | 8 | Current month, BCD |
| now_year | input | 12 | Current year, three BCD digits |
| sec_strobe | input | 1 | One-cycle pulse after the calendar advances |
| alarm_irq | output | 1 | Alarm interrupt, level |

## Verification
The assertions assume `sec_strobe` is a single-cycle pulse, and that the time buses are stable in the strobe cycle. They also assume the data bus is at least 12 bits wide. The bench drives the time buses and the strobe together on the falling edge and drops the strobe one cycle later. It applies a vector table of control settings against alarm and time values. Directed tests then cover reset, masking, strobe gating, stickiness and clear priority.

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [2:0]    rd_sel,
  output logic [DW-1:0] rd_data,
  input  logic [7:0]    now_sec,
  input  logic [7:0]    now_min,
  input  logic [7:0]    now_hour,
  input  logic [7:0]    now_mday,
  input  logic [7:0]    now_mon,
  input  logic [11:0]   now_year,
  input  logic          sec_strobe,
  output logic          alarm_irq
);
  localparam logic [2:0] SEL_CTRL = 3'd0;
  localparam logic [2:0] SEL_SEC  = 3'd1;
  localparam logic [2:0] SEL_MIN  = 3'd2;
  localparam logic [2:0] SEL_HOUR = 3'd3;
  localparam logic [2:0] SEL_DAY  = 3'd4;
  localparam logic [2:0] SEL_MON  = 3'd5;
  localparam logic [2:0] SEL_YEAR = 3'd6;
  localparam logic [2:0] SEL_STAT = 3'd7;

  logic [6:0]  ctrl_q;
  logic [6:0]  a_sec, a_min;
  logic [5:0]  a_hour, a_day;
  logic [4:0]  a_mon;
  logic [11:0] a_year;
  logic        pend;
  logic [5:0]  hit;
  logic        fire, clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      a_sec  <= '0;
      a_min  <= '0;
      a_hour <= '0;
      a_day  <= '0;
      a_mon  <= '0;
      a_year <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_CTRL: ctrl_q <= wr_data[6:0];
        SEL_SEC:  a_sec  <= wr_data[6:0];
        SEL_MIN:  a_min  <= wr_data[6:0];
        SEL_HOUR: a_hour <= wr_data[5:0];
        SEL_DAY:  a_day  <= wr_data[5:0];
        SEL_MON:  a_mon  <= wr_data[4:0];
        SEL_YEAR: a_year <= wr_data[11:0];
        default:  ;
      endcase
    end
  end

  assign hit[0] = ({1'b0, a_sec}  == now_sec);
  assign hit[1] = ({1'b0, a_min}  == now_min);
  assign hit[2] = ({2'b0, a_hour} == now_hour);
  assign hit[3] = ({2'b0, a_day}  == now_mday);
  assign hit[4] = ({3'b0, a_mon}  == now_mon);
  assign hit[5] = (a_year == now_year);

  assign fire = sec_strobe & ctrl_q[6] & |(hit & ctrl_q[5:0]);
  assign clr  = wr_en & (wr_sel == SEL_STAT) & wr_data[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pend <= 1'b0;
    else if (fire) pend <= 1'b1;
    else if (clr)  pend <= 1'b0;
  end

  assign alarm_irq = pend;

  always_comb begin
    case (rd_sel)
      SEL_CTRL: rd_data = DW'(ctrl_q);
      SEL_SEC:  rd_data = DW'(a_sec);
      SEL_MIN:  rd_data = DW'(a_min);
      SEL_HOUR: rd_data = DW'(a_hour);
      SEL_DAY:  rd_data = DW'(a_day);
      SEL_MON:  rd_data = DW'(a_mon);
      SEL_YEAR: rd_data = DW'(a_year);
      default:  rd_data = DW'({pend, 1'b0});
    endcase
  end

  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[6] && !alarm_irq) |=> !alarm_irq); // R4
  AST_SET_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_irq && !sec_strobe) |=> !alarm_irq); // R6
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_STAT && wr_data[1] && !sec_strobe) |=> !alarm_irq); // R9
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_irq && !(wr_en && wr_sel == SEL_STAT && wr_data[1])) |=> alarm_irq); // R8
  AST_SEC_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == SEL_SEC) |-> (rd_data[DW-1:7] == '0)); // R2
  AST_YEAR_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == SEL_YEAR) |-> (rd_data[DW-1:12] == '0)); // R2
endmodule

// File: tb/rtc_alarm_match_bench.sv
module rtc_alarm_match_bench;
  localparam int DW = 16;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          wr_en = 0;
  logic [2:0]    wr_sel = '0;
  logic [DW-1:0] wr_data = '0;
  logic [2:0]    rd_sel = '0;
  logic [DW-1:0] rd_data;
  logic [7:0]    now_sec = '0, now_min = '0, now_hour = '0, now_mday = '0, now_mon = '0;
  logic [11:0]   now_year = '0;
  logic          sec_strobe = 0;
  logic          alarm_irq;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  rtc_alarm_match #(.DW(DW)) u_rtc_alarm_match (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .now_sec(now_sec), .now_min(now_min),
    .now_hour(now_hour), .now_mday(now_mday), .now_mon(now_mon), .now_year(now_year),
    .sec_strobe(sec_strobe), .alarm_irq(alarm_irq));

  typedef struct packed {
    logic [6:0]  ctrl;
    logic [7:0]  a_sec, a_min, a_hour, a_day, a_mon;
    logic [11:0] a_year;
    logic [7:0]  n_sec, n_min, n_hour, n_day, n_mon;
    logic [11:0] n_year;
    logic        exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{7'h41, 8'h30, 8'h15, 8'h10, 8'h05, 8'h03, 12'h124, 8'h30, 8'h16, 8'h11, 8'h06, 8'h04, 12'h125, 1'b1},
    '{7'h41, 8'h30, 8'h15, 8'h10, 8'h05, 8'h03, 12'h124, 8'h31, 8'h15, 8'h10, 8'h05, 8'h03, 12'h124, 1'b0},
    '{7'h42, 8'h30, 8'h59, 8'h10, 8'h05, 8'h03, 12'h124, 8'h31, 8'h59, 8'h11, 8'h06, 8'h04, 12'h125, 1'b1},
    '{7'h44, 8'h30, 8'h15, 8'h23, 8'h05, 8'h03, 12'h124, 8'h31, 8'h16, 8'h23, 8'h06, 8'h04, 12'h125, 1'b1},
    '{7'h48, 8'h30, 8'h15, 8'h10, 8'h31, 8'h03, 12'h124, 8'h31, 8'h16, 8'h11, 8'h31, 8'h04, 12'h125, 1'b1},
    '{7'h50, 8'h30, 8'h15, 8'h10, 8'h05, 8'h12, 12'h124, 8'h31, 8'h16, 8'h11, 8'h06, 8'h12, 12'h125, 1'b1},
    '{7'h60, 8'h30, 8'h15, 8'h10, 8'h05, 8'h03, 12'h123, 8'h31, 8'h16, 8'h11, 8'h06, 8'h04, 12'h123, 1'b1},
    '{7'h60, 8'h30, 8'h15, 8'h10, 8'h05, 8'h03, 12'h123, 8'h31, 8'h16, 8'h11, 8'h06, 8'h04, 12'h023, 1'b0},
    '{7'h3F, 8'h30, 8'h15, 8'h10, 8'h05, 8'h03, 12'h124, 8'h30, 8'h15, 8'h10, 8'h05, 8'h03, 12'h124, 1'b0},
    '{7'h43, 8'h30, 8'h15, 8'h10, 8'h05, 8'h03, 12'h124, 8'h31, 8'h15, 8'h11, 8'h06, 8'h04, 12'h125, 1'b1},
    '{7'h7F, 8'h30, 8'h15, 8'h10, 8'h05, 8'h03, 12'h124, 8'h31, 8'h16, 8'h11, 8'h06, 8'h04, 12'h125, 1'b0}
  };

  task automatic wr(input logic [2:0] sel, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_now(input vec_t v);
    now_sec = v.n_sec; now_min = v.n_min; now_hour = v.n_hour;
    now_mday = v.n_day; now_mon = v.n_mon; now_year = v.n_year;
  endtask

  task automatic strobe();
    @(negedge clk);
    sec_strobe = 1;
    @(negedge clk);
    sec_strobe = 0;
  endtask

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_check(input string req, input logic [2:0] sel, input logic [DW-1:0] exp);
    rd_sel = sel;
    #1;
    check(req, rd_data, exp);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 irq", DW'(alarm_irq), '0);
    for (int s = 0; s < 8; s++) rd_check("R1 reg", 3'(s), '0);

    for (int i = 0; i < NV; i++) begin
      wr(3'd7, 16'h0002);
      wr(3'd0, DW'(VECS[i].ctrl));
      wr(3'd1, DW'(VECS[i].a_sec));
      wr(3'd2, DW'(VECS[i].a_min));
      wr(3'd3, DW'(VECS[i].a_hour));
      wr(3'd4, DW'(VECS[i].a_day));
      wr(3'd5, DW'(VECS[i].a_mon));
      wr(3'd6, DW'(VECS[i].a_year));
      set_now(VECS[i]);
      strobe();
      check($sformatf("R3 R4 R5 R7 vector %0d", i), DW'(alarm_irq), DW'(VECS[i].exp));
    end

    wr(3'd1, 16'hFFFF); rd_check("R2 sec", 3'd1, 16'h007F);
    wr(3'd2, 16'hFFFF); rd_check("R2 min", 3'd2, 16'h007F);
    wr(3'd3, 16'hFFFF); rd_check("R2 hour", 3'd3, 16'h003F);
    wr(3'd4, 16'hFFFF); rd_check("R2 day", 3'd4, 16'h003F);
    wr(3'd5, 16'hFFFF); rd_check("R2 mon", 3'd5, 16'h001F);
    wr(3'd6, 16'hFFFF); rd_check("R2 year", 3'd6, 16'h0FFF);
    wr(3'd0, 16'hFFFF); rd_check("R2 ctrl", 3'd0, 16'h007F);

    wr(3'd7, 16'h0002);
    wr(3'd0, 16'h0041);
    wr(3'd1, 16'h0042);
    now_sec = 8'h42;
    repeat (4) @(negedge clk);
    check("R6 no strobe", DW'(alarm_irq), '0);
    strobe();
    check("R6 after strobe", DW'(alarm_irq), 16'h1);
    now_sec = 8'h43;
    strobe();
    check("R8 sticky", DW'(alarm_irq), 16'h1);
    rd_check("R8 status", 3'd7, 16'h0002);
    wr(3'd7, 16'h0001);
    check("R9 zero bit no effect", DW'(alarm_irq), 16'h1);
    wr(3'd7, 16'h0002);
    check("R9 clear", DW'(alarm_irq), '0);
    rd_check("R9 status", 3'd7, 16'h0000);

    now_sec = 8'h42;
    @(negedge clk);
    wr_en = 1; wr_sel = 3'd7; wr_data = 16'h0002; sec_strobe = 1;
    @(negedge clk);
    wr_en = 0; sec_strobe = 0;
    check("R9 set wins", DW'(alarm_irq), 16'h1);

    rst_n = 0;
    @(negedge clk);
    check("R1 reset irq", DW'(alarm_irq), '0);
    rd_check("R1 reset ctrl", 3'd0, '0);
    rst_n = 1;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule